// File: doc/BRIEF.md
# Boot Signature Scanner

This controller runs once after reset to locate a bootable image in nonvolatile memory. After a single-cycle `start` pulse, it walks a short, fixed list of candidate start addresses. For each one it fetches one 32-bit word through a request/acknowledge read port and compares that word with the four-byte image signature, which is the ASCII characters `C`,`R`,`U`,`S` stored at increasing byte addresses.

The first candidate that holds the signature ends the search. The controller then publishes an entry address, which is the candidate plus four, so execution starts on the word just past the signature. If every candidate misses, the controller locks into a failure state. In that state it blinks `led` at a fixed period until the next reset.

The candidate list, the number of entries in use, the blink period and the byte order of the signature comparison are all parameters.

Top module: `boot_sig_scan`

## Requirements
- R1: After reset, `req`, `entry_valid`, `entry_addr` and `led` are all zero, and no read is issued until a `start` pulse arrives.
- R2: `req` stays high with a stable `addr` until the cycle in which `ack` is sampled high. In the cycle after that, `req` is low for at least one cycle before any further read.
- R3: Candidates are probed strictly in index order 0, 1, …, NUM_CAND-1, and the address for index i is `CAND_LIST[i*ADDR_W +: ADDR_W]`. The search stops at the first match, so later candidates are never read.
- R4: `rdata` is compared only in a cycle where `ack` is high. With SIG_BIG_ENDIAN=0 (the default), the signature word is 32'h53555243. With SIG_BIG_ENDIAN=1, it is 32'h43525553. Any other value, including the opposite byte order, is a miss.
- R5: On a match, `entry_valid` rises in the cycle after the accepting `ack`, and `entry_addr` equals the matching candidate plus 4. No read follows.
- R6: Once `entry_valid` is high, it stays high and `entry_addr` holds its value until reset. A later `start` has no effect.
- R7: When the last candidate misses, the block enters the failure state with `led` low. `led` inverts every BLINK_CYCLES clocks, with the first inversion BLINK_CYCLES clocks after entry.
- R8: Only reset leaves the failure state. In that state `start` is ignored and `req` stays low. After reset, a new search behaves normally.
- R9: A `start` pulse that arrives while a search is in progress does not restart or extend it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that launches the search |
| req | output | 1 | Read request, held until acknowledged |
| addr | output | ADDR_W | Byte address of the candidate being read |
| ack | input | 1 | Read completion, one cycle, at least one cycle after `req` rises |
| rdata | input | 32 | Read data, valid only while `ack` is high |
| entry_valid | output | 1 | Entry address found (level) |
| entry_addr | output | ADDR_W | Matching candidate plus 4 |
| led | output | 1 | Blinks in the failure state, otherwise low |

## Verification
A wrong candidate index shows on `addr` in the same cycle that `req` rises. A wrong sequencer state shows one clock later, as a `req` that does not drop after `ack` or that reappears after a match. A comparison that samples data outside `ack` is exposed by driving the signature word on `rdata` while `ack` is low, which produces an early match on the very next cycle. A miscounted blink divider drifts `led` away from its expected edge within one BLINK_CYCLES period of entering the failure state. For these reasons every output is compared with a behavioural model on every clock.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_READ = 3'd1,
    S_GAP  = 3'd2,
    S_DONE = 3'd3,
    S_FAIL = 3'd4
  } scan_state_t;

  localparam int SIG_BYTES = 4;

  // Signature characters at increasing byte addresses: 'C' 'R' 'U' 'S'
  function automatic logic [31:0] sig_word(input bit big_endian);
    logic [7:0] c0, c1, c2, c3;
    c0 = 8'h43;
    c1 = 8'h52;
    c2 = 8'h55;
    c3 = 8'h53;
    if (big_endian) return {c0, c1, c2, c3};
    return {c3, c2, c1, c0};
  endfunction

  // Entry point skips the signature word
  function automatic logic [63:0] skip_sig(input logic [63:0] base);
    return base + 64'(SIG_BYTES);
  endfunction

endpackage

// File: rtl/bscan_cand.sv
module bscan_cand #(
  parameter int ADDR_W   = 32,
  parameter int MAX_CAND = 8,
  parameter int NUM_CAND = 3,
  parameter logic [MAX_CAND*ADDR_W-1:0] CAND_LIST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  output logic [ADDR_W-1:0] cand_addr,
  output logic              last
);
  localparam int IW = (MAX_CAND > 1) ? $clog2(MAX_CAND) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_CAND - 1);

  logic [ADDR_W-1:0] table_w [MAX_CAND];
  logic [IW-1:0]     idx;

  for (genvar g = 0; g < MAX_CAND; g++) begin : g_tab
    assign table_w[g] = CAND_LIST[g*ADDR_W +: ADDR_W];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) idx <= '0;
    else if (adv)   idx <= idx + 1'b1;
  end

  assign cand_addr = table_w[idx];
  assign last      = (idx == LAST_IDX);

  // R3: index never walks past the used part of the list
  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST_IDX);
  // R3: advancing is only requested when a later candidate exists
  a_r3_adv_not_last: assert property (@(posedge clk) disable iff (rst)
    adv |-> !last);
endmodule

// File: rtl/bscan_fsm.sv
module bscan_fsm
  import bscan_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        ack,
  input  logic        hit,
  input  logic        last,
  output logic        req,
  output logic        clr_idx,
  output logic        adv_idx,
  output logic        take_entry,
  output logic        in_fail
);
  scan_state_t state, nxt;

  always_comb begin
    nxt        = state;
    clr_idx    = 1'b0;
    adv_idx    = 1'b0;
    take_entry = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        nxt     = S_READ;
        clr_idx = 1'b1;
      end
      S_READ: if (ack) begin
        if (hit) begin
          take_entry = 1'b1;
          nxt        = S_DONE;
        end else if (last) begin
          nxt = S_FAIL;
        end else begin
          adv_idx = 1'b1;
          nxt     = S_GAP;
        end
      end
      S_GAP:   nxt = S_READ;
      S_DONE:  nxt = S_DONE;
      S_FAIL:  nxt = S_FAIL;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

  assign req     = (state == S_READ);
  assign in_fail = (state == S_FAIL);

  // R2: request persists until acknowledged
  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req);
  // R2: an accepted read is followed by a request-free cycle
  a_r2_req_gap: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> !req);
  // R8: failure is terminal
  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    in_fail |=> in_fail);
  // R6: success is terminal
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == S_DONE) |=> (state == S_DONE));
endmodule

// File: rtl/bscan_blink.sv
module bscan_blink #(
  parameter int BLINK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic in_fail,
  output logic led
);
  localparam int CW = $clog2(BLINK_CYCLES + 1);
  localparam logic [CW-1:0] WRAP_AT = CW'(BLINK_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = in_fail && (cnt == WRAP_AT);

  always_ff @(posedge clk) begin
    if (rst || !in_fail) begin
      cnt <= '0;
      led <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      led <= ~led;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: LED dark outside the failure state
  a_r7_dark_outside_fail: assert property (@(posedge clk) disable iff (rst)
    !in_fail |-> !led);
  // R7: LED changes only at the end of a full period
  a_r7_toggle_period: assert property (@(posedge clk) disable iff (rst)
    (in_fail && !wrap) |=> $stable(led));
endmodule

// File: rtl/boot_sig_scan.sv
module boot_sig_scan
  import bscan_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int MAX_CAND       = 8,
  parameter int NUM_CAND       = 3,
  parameter logic [MAX_CAND*ADDR_W-1:0] CAND_LIST =
    {160'h0, 32'h6100_0000, 32'h6040_0000, 32'h6000_0000},
  parameter int BLINK_CYCLES   = 16,
  parameter bit SIG_BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  input  logic              ack,
  input  logic [31:0]       rdata,
  output logic              entry_valid,
  output logic [ADDR_W-1:0] entry_addr,
  output logic              led
);
  localparam logic [31:0] SIG = sig_word(SIG_BIG_ENDIAN);

  logic              clr_idx, adv_idx, take_entry, in_fail, last, hit;
  logic [ADDR_W-1:0] cand_addr;
  logic [63:0]       entry_wide;

  bscan_cand #(
    .ADDR_W(ADDR_W), .MAX_CAND(MAX_CAND),
    .NUM_CAND(NUM_CAND), .CAND_LIST(CAND_LIST)
  ) u_cand (
    .clk(clk), .rst(rst), .clr(clr_idx), .adv(adv_idx),
    .cand_addr(cand_addr), .last(last)
  );

  bscan_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .ack(ack), .hit(hit), .last(last),
    .req(req), .clr_idx(clr_idx), .adv_idx(adv_idx),
    .take_entry(take_entry), .in_fail(in_fail)
  );

  bscan_blink #(.BLINK_CYCLES(BLINK_CYCLES)) u_blink (
    .clk(clk), .rst(rst), .in_fail(in_fail), .led(led)
  );

  assign hit        = ack && (rdata == SIG);
  assign addr       = cand_addr;
  assign entry_wide = skip_sig(64'(cand_addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_valid <= 1'b0;
      entry_addr  <= '0;
    end else if (take_entry) begin
      entry_valid <= 1'b1;
      entry_addr  <= entry_wide[ADDR_W-1:0];
    end
  end

  // R2: address does not move while a read is outstanding
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> $stable(addr));
  // R6: entry result is a held level
  a_r6_entry_hold: assert property (@(posedge clk) disable iff (rst)
    entry_valid |=> (entry_valid && $stable(entry_addr)));
  // R5: no read once the entry is published
  a_r5_no_read_after_entry: assert property (@(posedge clk) disable iff (rst)
    entry_valid |-> !req);
  // R5/R8: success and failure are exclusive
  a_r8_fail_excludes_entry: assert property (@(posedge clk) disable iff (rst)
    !(entry_valid && in_fail));
endmodule

// File: tb/test_boot_sig_scan.sv
`timescale 1ns/1ps
module test_boot_sig_scan;
  localparam int BLINK = 16;
  localparam logic [31:0] SIGW  = {8'h53, 8'h55, 8'h52, 8'h43};
  localparam logic [31:0] SIGSW = {8'h43, 8'h52, 8'h55, 8'h53};
  localparam logic [31:0] CAND [3] = '{32'h6000_0000, 32'h6040_0000, 32'h6100_0000};

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, ack = 1'b0;
  logic [31:0] rdata = 32'h0;
  logic        req, entry_valid, led;
  logic [31:0] addr, entry_addr;

  always #4 clk = ~clk;

  boot_sig_scan i_boot_sig_scan (
    .clk(clk), .rst(rst), .start(start), .req(req), .addr(addr),
    .ack(ack), .rdata(rdata), .entry_valid(entry_valid),
    .entry_addr(entry_addr), .led(led)
  );

  int checks = 0, errors = 0, nreads = 0, wcnt = 0, lat_sel = 0, cyc = 0;
  bit armed = 0, ended = 0;
  logic [31:0] mem_val [3];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] lookup(input logic [31:0] a);
    for (int i = 0; i < 3; i++) if (a == CAND[i]) return mem_val[i];
    return 32'h0;
  endfunction

  // Memory responder: latency 1..4 cycles, decoy signature on rdata while ack low
  always @(negedge clk) begin
    if (req && !ack) begin
      if (wcnt >= 1 + (lat_sel % 4)) begin
        ack = 1'b1; rdata = lookup(addr); wcnt = 0; lat_sel++; nreads++;
      end else begin
        wcnt++; rdata = SIGW;
      end
    end else begin
      ack = 1'b0; wcnt = 0; rdata = SIGW;
    end
  end

  // Behavioural reference: 0 idle, 1 reading, 2 gap, 3 done, 4 fail
  int m_st = 0, m_idx = 0, m_cnt = 0;
  bit m_ev = 0, m_led = 0;
  logic [31:0] m_ea = 32'h0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_idx = 0; m_cnt = 0; m_ev = 0; m_led = 0; m_ea = 0;
    end else begin
      case (m_st)
        0: if (start) begin m_st = 1; m_idx = 0; end
        1: if (ack) begin
             if (rdata == SIGW) begin m_ev = 1; m_ea = CAND[m_idx] + 32'd4; m_st = 3; end
             else if (m_idx == 2) m_st = 4;
             else begin m_idx++; m_st = 2; end
           end
        2: m_st = 1;
        4: begin m_cnt++; if (m_cnt == BLINK) begin m_cnt = 0; m_led = !m_led; end end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      chk(req == (m_st == 1), "R2 req", 32'(req), 32'(m_st == 1));
      if (m_st == 1) chk(addr == CAND[m_idx], "R3 addr", addr, CAND[m_idx]);
      chk(entry_valid == m_ev, "R5 entry_valid", 32'(entry_valid), 32'(m_ev));
      chk(entry_addr == m_ea, "R6 entry_addr", entry_addr, m_ea);
      chk(led == m_led, "R7 led", 32'(led), 32'(m_led));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 50000);
      finish_up();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1; armed = 0;
    repeat (3) @(negedge clk);
    nreads = 0;
    rst = 0; armed = 1;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  initial begin
    int toggles;
    logic prev;
    mem_val = '{32'h0, 32'h0, 32'h0};
    do_reset();
    // R1: reset values and idle without start
    chk(req == 0, "R1 req", 32'(req), 0);
    chk(entry_valid == 0, "R1 entry_valid", 32'(entry_valid), 0);
    chk(entry_addr == 0, "R1 entry_addr", entry_addr, 0);
    chk(led == 0, "R1 led", 32'(led), 0);
    repeat (6) @(negedge clk);
    chk(nreads == 0, "R1 idle", nreads, 0);

    // R5: match at first candidate
    mem_val = '{SIGW, 32'h0, 32'h0};
    pulse_start();
    repeat (30) @(negedge clk);
    chk(entry_valid == 1, "R5 found", 32'(entry_valid), 1);
    chk(entry_addr == CAND[0] + 4, "R5 entry", entry_addr, CAND[0] + 4);
    chk(nreads == 1, "R3 reads", nreads, 1);
    // R6: start after success ignored
    pulse_start();
    repeat (20) @(negedge clk);
    chk(nreads == 1, "R6 no reread", nreads, 1);
    chk(entry_addr == CAND[0] + 4, "R6 hold", entry_addr, CAND[0] + 4);

    // R4: opposite byte order is a miss, last candidate matches
    do_reset();
    mem_val = '{32'h0, SIGSW, SIGW};
    pulse_start();
    repeat (60) @(negedge clk);
    chk(entry_addr == CAND[2] + 4, "R4 entry", entry_addr, CAND[2] + 4);
    chk(nreads == 3, "R4 reads", nreads, 3);

    // R3 first match wins; R9 start during search ignored
    do_reset();
    mem_val = '{32'h1234_5678, SIGW, SIGW};
    pulse_start();
    repeat (2) @(negedge clk);
    pulse_start();
    repeat (60) @(negedge clk);
    chk(entry_addr == CAND[1] + 4, "R3 first", entry_addr, CAND[1] + 4);
    chk(nreads == 2, "R9 reads", nreads, 2);

    // R7: no match -> blinking
    do_reset();
    mem_val = '{32'h0, SIGSW, 32'hFFFF_FFFF};
    pulse_start();
    repeat (30) @(negedge clk);
    chk(nreads == 3, "R7 reads", nreads, 3);
    chk(entry_valid == 0, "R7 no entry", 32'(entry_valid), 0);
    toggles = 0; prev = led;
    for (int k = 0; k < 4 * BLINK; k++) begin
      @(negedge clk);
      if (led != prev) toggles++;
      prev = led;
    end
    chk(toggles == 4, "R7 toggles", toggles, 4);
    // R8: start ignored in failure, reset exits
    pulse_start();
    repeat (20) @(negedge clk);
    chk(nreads == 3, "R8 no read", nreads, 3);
    chk(req == 0, "R8 req", 32'(req), 0);
    do_reset();
    chk(led == 0, "R8 led after reset", 32'(led), 0);
    mem_val = '{SIGW, 32'h0, 32'h0};
    pulse_start();
    repeat (30) @(negedge clk);
    chk(entry_valid == 1, "R8 restart", 32'(entry_valid), 1);
    finish_up();
  end
endmodule